// File: doc/BRIEF.md
# Flash Block Unlock Sweep Sequencer

This block runs once at startup, ahead of any flash file system access, and prepares every erase block of a NOR flash that uses the common command-set flash protocol. After a start pulse it visits the blocks in ascending order. At each block it clears the status, puts the array in read mode, and unlocks the block. It then polls until the device's internal state machine reports that it is ready.

Next, the sequencer requests the status word and samples it once. If that word shows an erase that was suspended and never finished, the sequencer resumes the erase and polls until the erase completes. Every visit ends by returning the block to read-array mode.

The flash is seen as a plain bus:
- A write strobe puts one command on the bus in a single cycle.
- A read strobe samples the 16-bit data bus in the same cycle.

Each poll is bounded by a parameterized read limit. A poll that never reports ready raises a sticky error flag and cuts the sweep short.

Top module: `flash_unlock_sweep`

## Requirements
- R1: For each visited block the sequencer writes, in this order and to the block base address, the commands 0x50, 0xFF, 0x60 and 0xD0, one per cycle.
- R2: After the unlock command it reads the block address on every cycle until data bit 7 is 1, and issues no write while polling.
- R3: Once bit 7 is seen, it writes 0x70 and samples the status word with exactly one read.
- R4: If that sampled word has bit 6 set, it writes 0xD0 and then 0x70, then polls until bit 7 is 1. If bit 6 is clear, it writes neither of these extra commands.
- R5: Every block visit ends with a write of 0xFF to the block base address.
- R6: Blocks are visited from index 0 up to the block count minus one. The base address of block i is BASE_ADDR + i*BLOCK_SIZE.
- R7: `done` is high for exactly one cycle, right after the final 0xFF write. With a block count of zero, `done` pulses one cycle after start and no bus access occurs.
- R8: A start pulse while `busy` is high has no effect: the command stream and the single `done` pulse are those of the first start.
- R9: If a poll makes POLL_LIMIT reads without seeing bit 7, `err` goes high and the current block still receives 0xFF. No later block is visited, and `done` then pulses. `err` stays high until the next accepted start clears it.
- R10: After reset, `wr_en`, `rd_en`, `busy`, `done` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (taken only when idle) |
| num_blocks | input | BLK_W | Number of blocks to visit, sampled at start |
| rd_data | input | 16 | Flash read data, valid in the cycle of `rd_en` |
| wr_en | output | 1 | Single-cycle command write strobe |
| rd_en | output | 1 | Single-cycle read strobe |
| addr | output | ADDR_W | Block base address for the current access |
| wr_data | output | 16 | Command word |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky poll timeout flag |

## Verification
The bench uses different unlock delays per block, so a sequencer that read the status too early or counted the polls wrongly shows up in the read total. It marks only some blocks as suspended, so a design that always or never took the resume branch produces the wrong command log. A zero block count catches a design that wraps its index and sweeps 2^BLK_W blocks. A second start during a sweep catches a restart or a duplicated `done`. A block that never becomes ready catches three faults: a design that hangs, one that forgets to park the block in read-array mode, or one that carries on to later blocks.

// File: rtl/flash_unlock_sweep.sv
module flash_unlock_sweep #(
  parameter int ADDR_W = 24,
  parameter int BLK_W = 8,
  parameter int POLL_LIMIT = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [ADDR_W-1:0] BLOCK_SIZE = ADDR_W'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  num_blocks,
  input  logic [15:0]       rd_data,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic [15:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam logic [15:0] C_CLR = 16'h0050;
  localparam logic [15:0] C_ARR = 16'h00FF;
  localparam logic [15:0] C_CFG = 16'h0060;
  localparam logic [15:0] C_GO  = 16'h00D0;
  localparam logic [15:0] C_STS = 16'h0070;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_ARR, S_CFG, S_UNL, S_PUNL, S_STS, S_SAMP,
    S_RES, S_STS2, S_PERS, S_FIN, S_DONE
  } st_t;

  st_t              st;
  logic [BLK_W-1:0] blk_q, cnt_q;
  logic [PC_W-1:0]  pcnt;
  logic             ready, last_blk, poll_expire;
  logic             unused_bits;

  assign ready       = rd_data[7];
  assign last_blk    = (blk_q == BLK_W'(cnt_q - 1'b1));
  assign poll_expire = (pcnt == PC_W'(POLL_LIMIT - 1));
  assign unused_bits = ^{rd_data[15:8], rd_data[5:0]};

  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);
  assign rd_en = (st == S_PUNL) || (st == S_SAMP) || (st == S_PERS);
  assign addr  = BASE_ADDR + ADDR_W'(blk_q) * BLOCK_SIZE;

  always_comb begin
    wr_en   = 1'b1;
    wr_data = 16'h0000;
    case (st)
      S_CLR:         wr_data = C_CLR;
      S_ARR, S_FIN:  wr_data = C_ARR;
      S_CFG:         wr_data = C_CFG;
      S_UNL, S_RES:  wr_data = C_GO;
      S_STS, S_STS2: wr_data = C_STS;
      default:       wr_en   = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      blk_q <= '0;
      cnt_q <= '0;
      pcnt  <= '0;
      err   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          blk_q <= '0;
          cnt_q <= num_blocks;
          err   <= 1'b0;
          st    <= (num_blocks == '0) ? S_DONE : S_CLR;
        end
        S_CLR: st <= S_ARR;
        S_ARR: st <= S_CFG;
        S_CFG: st <= S_UNL;
        S_UNL: begin
          pcnt <= '0;
          st   <= S_PUNL;
        end
        S_PUNL: begin
          if (ready) st <= S_STS;
          else if (poll_expire) begin
            err <= 1'b1;
            st  <= S_FIN;
          end else pcnt <= pcnt + 1'b1;
        end
        S_STS:  st <= S_SAMP;
        S_SAMP: st <= rd_data[6] ? S_RES : S_FIN;
        S_RES:  st <= S_STS2;
        S_STS2: begin
          pcnt <= '0;
          st   <= S_PERS;
        end
        S_PERS: begin
          if (ready) st <= S_FIN;
          else if (poll_expire) begin
            err <= 1'b1;
            st  <= S_FIN;
          end else pcnt <= pcnt + 1'b1;
        end
        S_FIN: begin
          if (err || last_blk) st <= S_DONE;
          else begin
            blk_q <= blk_q + 1'b1;
            st    <= S_CLR;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  assert_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> busy);
  assert_block_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> (blk_q < cnt_q));
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PC_W'(POLL_LIMIT));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(st == S_IDLE && start)) |=> err);
  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(busy)) |-> $stable(addr));

endmodule

// File: tb/flash_unlock_sweep_tb.sv
module flash_unlock_sweep_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] num_blocks = 0;
  logic [15:0] rd_data;
  logic wr_en, rd_en, busy, done, err;
  logic [23:0] addr;
  logic [15:0] wr_data;

  always #5 clk = ~clk;

  flash_unlock_sweep #(.ADDR_W(24), .BLK_W(8), .POLL_LIMIT(32),
    .BASE_ADDR(24'h000000), .BLOCK_SIZE(24'h010000)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_blocks(num_blocks),
    .rd_data(rd_data), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err));

  int errors = 0, checks = 0;
  int ud_cfg[0:15], ed_cfg[0:15];
  logic [15:0] susp_cfg;
  logic [15:0] susp;
  int ubusy, ebusy, nreads, nlog, ndone;
  logic [15:0] prev;
  logic mclr = 0;
  logic [23:0] log_a[0:255];
  logic [15:0] log_d[0:255];
  logic [23:0] exp_a[0:255];
  logic [15:0] exp_d[0:255];
  int nexp, exp_reads;
  logic [3:0] cur_b;

  assign cur_b = addr[19:16];
  assign rd_data = (ubusy > 0 || ebusy > 0) ? 16'h0000 :
                   {8'h00, 1'b1, susp[cur_b], 6'b000000};

  always @(posedge clk) begin
    if (mclr) begin
      ubusy <= 0; ebusy <= 0; nreads <= 0; nlog <= 0; prev <= 16'h0;
      susp <= susp_cfg;
    end else begin
      if (wr_en) begin
        if (nlog < 256) begin log_a[nlog] <= addr; log_d[nlog] <= wr_data; end
        nlog <= nlog + 1;
        prev <= wr_data;
        if (wr_data == 16'hD0 && prev == 16'h60) ubusy <= ud_cfg[cur_b];
        if (wr_data == 16'hD0 && prev == 16'h70 && susp[cur_b]) begin
          susp[cur_b] <= 1'b0;
          ebusy <= ed_cfg[cur_b];
        end
      end
      if (rd_en) begin
        nreads <= nreads + 1;
        if (ubusy > 0) ubusy <= ubusy - 1;
        else if (ebusy > 0) ebusy <= ebusy - 1;
      end
    end
  end

  always @(negedge clk) if (done) ndone++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic push(input int b, input logic [15:0] d);
    exp_a[nexp] = 24'(b) << 16;
    exp_d[nexp] = d;
    nexp++;
  endtask

  // Expected stream per R1, R3, R4, R5, R6; abort_b marks a block whose unlock never finishes (R9)
  task automatic build(input int n, input int abort_b);
    nexp = 0; exp_reads = 0;
    for (int b = 0; b < n; b++) begin
      push(b, 16'h50); push(b, 16'hFF); push(b, 16'h60); push(b, 16'hD0);
      if (b == abort_b) begin
        exp_reads += 32;
        push(b, 16'hFF);
        break;
      end
      exp_reads += ud_cfg[b] + 1;
      push(b, 16'h70);
      exp_reads += 1;
      if (susp_cfg[b]) begin
        push(b, 16'hD0); push(b, 16'h70);
        exp_reads += ed_cfg[b] + 1;
      end
      push(b, 16'hFF);
    end
  endtask

  task automatic compare_log(input string req);
    chk(nlog == nexp, {req, " write count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      if (log_d[i] !== exp_d[i]) begin
        chk(0, {req, " command"}, int'(log_d[i]), int'(exp_d[i])); return;
      end
      if (log_a[i] !== exp_a[i]) begin
        chk(0, {req, " R6 address"}, int'(log_a[i]), int'(exp_a[i])); return;
      end
    end
    chk(1, req, 0, 0);
  endtask

  task automatic model_reset();
    @(negedge clk); mclr = 1;
    @(negedge clk); mclr = 0;
    ndone = 0;
  endtask

  task automatic run(input int n, input int restart_at, output int cyc);
    @(negedge clk); start = 1; num_blocks = 8'(n);
    cyc = 0;
    do begin
      @(negedge clk); start = 0; cyc++;
      if (cyc == restart_at) begin start = 1; num_blocks = 8'd7; end
    end while (!done && cyc < 5000);
    chk(cyc < 5000, "R7 done reached", cyc, 0);
    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0, "R7 done single cycle", int'(done), 0);
    chk(ndone == 1, "R7 done pulse count", ndone, 1);
  endtask

  task automatic t_reset();
    chk(wr_en == 0 && rd_en == 0, "R10 strobes after reset", int'({wr_en, rd_en}), 0);
    chk(busy == 0 && done == 0 && err == 0, "R10 flags after reset", int'({busy, done, err}), 0);
  endtask

  task automatic t_plain();
    int c;
    ud_cfg[0] = 0; ud_cfg[1] = 2; ud_cfg[2] = 5; susp_cfg = 16'h0000;
    model_reset(); build(3, -1);
    run(3, -1, c);
    compare_log("R1 R3 R5 plain sweep");
    chk(nreads == exp_reads, "R2 poll reads", nreads, exp_reads);
    chk(err == 0, "R9 no error", int'(err), 0);
  endtask

  task automatic t_suspend();
    int c;
    ud_cfg[0] = 1; ud_cfg[1] = 0; ud_cfg[2] = 3; ud_cfg[3] = 0;
    ed_cfg[1] = 4; ed_cfg[3] = 0; susp_cfg = 16'b1010;
    model_reset(); build(4, -1);
    run(4, -1, c);
    compare_log("R4 resume branch");
    chk(nreads == exp_reads, "R4 erase poll reads", nreads, exp_reads);
  endtask

  task automatic t_zero();
    int c;
    susp_cfg = 0;
    model_reset(); build(0, -1);
    run(0, -1, c);
    chk(c == 1, "R7 zero count latency", c, 1);
    chk(nlog == 0 && nreads == 0, "R7 zero count no access", nlog + nreads, 0);
  endtask

  task automatic t_restart();
    int c;
    ud_cfg[0] = 3; ud_cfg[1] = 1; susp_cfg = 16'b01; ed_cfg[0] = 2;
    model_reset(); build(2, -1);
    run(2, 6, c);
    compare_log("R8 start ignored while busy");
  endtask

  task automatic t_timeout();
    int c;
    ud_cfg[0] = 0; ud_cfg[1] = 1000; ud_cfg[2] = 0; susp_cfg = 0;
    model_reset(); build(3, 1);
    run(3, -1, c);
    chk(err == 1, "R9 error raised", int'(err), 1);
    compare_log("R9 abort stream");
    chk(nreads == exp_reads, "R9 timeout reads", nreads, exp_reads);
    ud_cfg[1] = 0;
    model_reset(); build(2, -1);
    run(2, -1, c);
    chk(err == 0, "R9 error cleared by start", int'(err), 0);
    compare_log("R6 rerun after error");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin ud_cfg[i] = 0; ed_cfg[i] = 0; end
    susp_cfg = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_plain();
    t_suspend();
    t_zero();
    t_restart();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule